// File: doc/BRIEF.md
# Filtered Signal Power Detector

This block measures the power of a stream of signed samples. For every enabled sample it forms the squared magnitude. At build time it works either on a complex pair (I² + Q²) or on a single real rail (I² alone or Q² alone). The squared value is saturated to the output width. It then passes through two first-order exponential smoothing filters in cascade. Each filter has its own coefficient port, and the coefficients may be changed while the block runs.

A typical use is a receive-level monitor or an automatic gain loop. Software reads the smoothed power word and does any square root, RMS or decibel conversion itself. Only enabled samples move the filters. The block raises a one-cycle valid strobe each time the smoothed output takes a new value.

Top module: `pwr_detector`

## Requirements
- R1: With COMPLEX_EN=1 (USE_I=1, USE_Q=1), the instantaneous power is smp_i² + smp_q², both inputs taken as signed two's-complement.
- R2: With COMPLEX_EN=0 and only USE_I set, the power is smp_i² and smp_q has no effect. With only USE_Q set, the power is smp_q² and smp_i has no effect.
- R3: A power value above 2^(2·DATA_W−2)−1 is clamped to that value. Examples are a negative full-scale real sample, or two full-scale components in complex mode.
- R4: Each filter state holds ALPHA_W fraction bits. On an update it becomes s + floor(alpha·(x − s) / 2^ALPHA_W), with alpha read as an unsigned integer, so the coefficient is alpha/2^ALPHA_W. The first stage's x is power·2^ALPHA_W. The second stage's x is the first stage's full state. pwr_o is the integer part of the second state.
- R5: pwr_vld_o pulses for one cycle exactly 4 clock edges after each edge that samples smp_en high. Samples may arrive on every cycle.
- R6: While smp_en is low, pwr_o and both filter states keep their values, whatever the sample and coefficient inputs do.
- R7: init high at a clock edge clears the pipeline and both filter states: pwr_o becomes 0 and pwr_vld_o becomes 0. It takes priority over smp_en, and the block then restarts from zero.
- R8: Each filter update lands between the stage's old state and its input. A constant input therefore drives pwr_o monotonically toward the input power and never past it.
- R9: With both coefficients at 2^ALPHA_W−1, three enabled samples of a constant power P leave pwr_o at P−1 or P (within one LSB per stage).
- R10: A coefficient of 0 freezes its stage. From reset, pwr_o stays 0 when alpha1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| init | input | 1 | Synchronous clear of pipeline and filters, active high |
| smp_en | input | 1 | Qualifies the sample on smp_i/smp_q |
| smp_i | input | DATA_W | In-phase (or real) sample, signed |
| smp_q | input | DATA_W | Quadrature sample, signed |
| alpha1 | input | ALPHA_W | First-stage coefficient, unsigned fraction of 2^ALPHA_W |
| alpha2 | input | ALPHA_W | Second-stage coefficient, unsigned fraction of 2^ALPHA_W |
| pwr_o | output | 2*DATA_W-2 | Smoothed power, integer part |
| pwr_vld_o | output | 1 | One-cycle strobe when pwr_o takes a new value |

## Verification
The bound checker watches some properties on every cycle. It compares the valid strobe against a 4-deep history of smp_en. It confirms that both filter states stay frozen between updates and are cleared after init. It also checks that every update of either stage lands between the old state and that stage's input. The bench scenarios are needed for the rest: the exact squared-magnitude values in each build mode, clamping at the output maximum, the bit-exact rounding of the filter arithmetic under mixed coefficients, the convergence bound at the maximum coefficient, and the frozen output at a zero coefficient. The bench compares three instances, one per mode, against an integer model of the update rule.

// File: rtl/pwr_det_pkg.sv
package pwr_det_pkg;

   // Build-time selection of the squared-magnitude variant
   typedef enum logic [1:0] {
      PM_COMPLEX = 2'd0,
      PM_I_ONLY  = 2'd1,
      PM_Q_ONLY  = 2'd2,
      PM_INVALID = 2'd3
   } pwr_mode_e;

   // Clock edges from a sampled enable to the output strobe
   localparam int PWR_LATENCY = 4;

   function automatic pwr_mode_e pwr_mode_of(bit cplx, bit use_i, bit use_q);
      if (cplx) return (use_i && use_q) ? PM_COMPLEX : PM_INVALID;
      if (use_i && !use_q) return PM_I_ONLY;
      if (use_q && !use_i) return PM_Q_ONLY;
      return PM_INVALID;
   endfunction

endpackage

// File: rtl/pwr_square.sv
// Two register stages: squares, then (selected) sum with clamp to OUT_W bits.
module pwr_square
   import pwr_det_pkg::*;
#(
   parameter int        DATA_W = 12,
   parameter int        OUT_W  = 2*DATA_W-2,
   parameter pwr_mode_e MODE   = PM_COMPLEX
) (
   input  logic                     clk,
   input  logic                     init,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] d_i,
   input  logic signed [DATA_W-1:0] d_q,
   output logic [OUT_W-1:0]         pwr,
   output logic                     pwr_vld
);

   localparam int SQ_W  = 2*DATA_W;
   localparam int SUM_W = SQ_W+1;

   logic signed [SQ_W-1:0] ext_i, ext_q;
   logic [SQ_W-1:0]        sq_i, sq_q;
   logic                   sq_vld;
   logic [SUM_W-1:0]       sum;

   assign ext_i = {{DATA_W{d_i[DATA_W-1]}}, d_i};
   assign ext_q = {{DATA_W{d_q[DATA_W-1]}}, d_q};

   always_ff @(posedge clk) begin
      if (init) begin
         sq_i   <= '0;
         sq_q   <= '0;
         sq_vld <= 1'b0;
      end else begin
         sq_vld <= en;
         if (en) begin
            sq_i <= ext_i * ext_i;
            sq_q <= ext_q * ext_q;
         end
      end
   end

   generate
      if (MODE == PM_COMPLEX) begin : g_cplx
         assign sum = {1'b0, sq_i} + {1'b0, sq_q};
      end else if (MODE == PM_I_ONLY) begin : g_ionly
         assign sum = {1'b0, sq_i};
      end else begin : g_qonly
         assign sum = {1'b0, sq_q};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (init) begin
         pwr     <= '0;
         pwr_vld <= 1'b0;
      end else begin
         pwr_vld <= sq_vld;
         if (sq_vld) begin
            if (|sum[SUM_W-1:OUT_W]) pwr <= '1;
            else                     pwr <= sum[OUT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/pwr_ema_stage.sv
// One first-order smoothing stage: y += floor(alpha*(x-y) / 2^ALPHA_W).
module pwr_ema_stage #(
   parameter int ST_W    = 40,
   parameter int ALPHA_W = 18
) (
   input  logic               clk,
   input  logic               init,
   input  logic               upd,
   input  logic [ALPHA_W-1:0] alpha,
   input  logic [ST_W-1:0]    x,
   output logic [ST_W-1:0]    y,
   output logic               y_vld
);

   localparam int PW = ST_W+ALPHA_W+2;

   logic signed [PW-1:0] dif_w, alp_w, cur_w;

   assign cur_w = $signed({{(PW-ST_W){1'b0}}, y});
   assign dif_w = $signed({{(PW-ST_W){1'b0}}, x}) - cur_w;
   assign alp_w = $signed({{(PW-ALPHA_W){1'b0}}, alpha});

   always_ff @(posedge clk) begin
      if (init) begin
         y     <= '0;
         y_vld <= 1'b0;
      end else begin
         y_vld <= upd;
         if (upd) y <= ST_W'(cur_w + ((dif_w * alp_w) >>> ALPHA_W));
      end
   end

endmodule

// File: rtl/pwr_detector.sv
module pwr_detector
   import pwr_det_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int ALPHA_W    = 18,
   parameter bit COMPLEX_EN = 1'b1,
   parameter bit USE_I      = 1'b1,
   parameter bit USE_Q      = 1'b1
) (
   input  logic                     clk,
   input  logic                     init,
   input  logic                     smp_en,
   input  logic signed [DATA_W-1:0] smp_i,
   input  logic signed [DATA_W-1:0] smp_q,
   input  logic [ALPHA_W-1:0]       alpha1,
   input  logic [ALPHA_W-1:0]       alpha2,
   output logic [2*DATA_W-3:0]      pwr_o,
   output logic                     pwr_vld_o
);

   localparam int        OUT_W = 2*DATA_W-2;
   localparam int        ST_W  = OUT_W+ALPHA_W;
   localparam int        N_STG = 2;
   localparam pwr_mode_e MODE  = pwr_mode_of(COMPLEX_EN, USE_I, USE_Q);

   generate
      if (MODE == PM_INVALID) begin : g_bad_mode
         $error("pwr_detector: complex needs I and Q; real needs exactly one rail");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("pwr_detector: DATA_W must be at least 2");
      end
      if (ALPHA_W < 1 || ST_W+ALPHA_W+2 > 64) begin : g_bad_aw
         $error("pwr_detector: ALPHA_W out of range");
      end
   endgenerate

   logic [OUT_W-1:0]   pwr_q;
   logic               pwr_v;
   logic [ST_W-1:0]    ema_x [N_STG+1];
   logic               ema_v [N_STG+1];
   logic [ALPHA_W-1:0] alpha_a [N_STG];

   pwr_square #(.DATA_W(DATA_W), .OUT_W(OUT_W), .MODE(MODE)) u_sq (
      .clk     (clk),
      .init    (init),
      .en      (smp_en),
      .d_i     (smp_i),
      .d_q     (smp_q),
      .pwr     (pwr_q),
      .pwr_vld (pwr_v)
   );

   assign ema_x[0]   = {pwr_q, {ALPHA_W{1'b0}}};
   assign ema_v[0]   = pwr_v;
   assign alpha_a[0] = alpha1;
   assign alpha_a[1] = alpha2;

   generate
      for (genvar g = 0; g < N_STG; g++) begin : g_stg
         pwr_ema_stage #(.ST_W(ST_W), .ALPHA_W(ALPHA_W)) u_stg (
            .clk   (clk),
            .init  (init),
            .upd   (ema_v[g]),
            .alpha (alpha_a[g]),
            .x     (ema_x[g]),
            .y     (ema_x[g+1]),
            .y_vld (ema_v[g+1])
         );
      end
   endgenerate

   assign pwr_o     = ema_x[N_STG][ST_W-1:ALPHA_W];
   assign pwr_vld_o = ema_v[N_STG];

endmodule

// File: rtl/pwr_detector_chk.sv
module pwr_detector_chk #(
   parameter int DATA_W  = 12,
   parameter int ALPHA_W = 18,
   parameter int OW      = 2*DATA_W-2,
   parameter int SW      = OW+ALPHA_W
) (
   input logic          clk,
   input logic          init,
   input logic          ena,
   input logic          vld_o,
   input logic [OW-1:0] power_o,
   input logic [SW-1:0] x1,
   input logic [SW-1:0] y1,
   input logic [SW-1:0] y2,
   input logic          v1,
   input logic          v2
);

   // Reference history of accepted enables, 4 deep (fixed latency)
   logic [3:0] hist;
   always_ff @(posedge clk) begin
      if (init) hist <= '0;
      else      hist <= {hist[2:0], ena};
   end

   // R5: strobe follows the enable by exactly four edges
   p_latency_r5: assert property (@(posedge clk) disable iff (init)
      vld_o == hist[3]);

   // R6: states frozen when their stage is not updated
   p_hold_s1_r6: assert property (@(posedge clk) disable iff (init)
      !v1 |=> $stable(y1));
   p_hold_s2_r6: assert property (@(posedge clk) disable iff (init)
      !v2 |=> $stable(y2));

   // R7: init clears the output and the strobe on the next edge
   p_init_r7: assert property (@(posedge clk)
      init |=> (power_o == '0 && !vld_o && y1 == '0 && y2 == '0));

   // R8: each update lands between the old state and the stage input
   p_between_s1_r8: assert property (@(posedge clk) disable iff (init)
      v1 |=> (($past(x1) >= $past(y1)) ? (y1 >= $past(y1) && y1 <= $past(x1))
                                       : (y1 <= $past(y1) && y1 >= $past(x1))));
   p_between_s2_r8: assert property (@(posedge clk) disable iff (init)
      v2 |=> (($past(y1) >= $past(y2)) ? (y2 >= $past(y2) && y2 <= $past(y1))
                                       : (y2 <= $past(y2) && y2 >= $past(y1))));

endmodule

bind pwr_detector pwr_detector_chk #(.DATA_W(DATA_W), .ALPHA_W(ALPHA_W)) u_chk (
   .clk     (clk),
   .init    (init),
   .ena     (smp_en),
   .vld_o   (pwr_vld_o),
   .power_o (pwr_o),
   .x1      (ema_x[0]),
   .y1      (ema_x[1]),
   .y2      (ema_x[2]),
   .v1      (ema_v[0]),
   .v2      (ema_v[1])
);

// File: tb/sim_pwr_detector.sv
module sim_pwr_detector;

   localparam int     DW   = 12;
   localparam int     AW   = 18;
   localparam int     OW   = 2*DW-2;
   localparam longint AMAX = (64'sd1 <<< AW) - 1;
   localparam longint PMAX = (64'sd1 <<< OW) - 1;

   typedef struct packed {
      logic signed [DW-1:0] vi;
      logic signed [DW-1:0] vq;
      logic [AW-1:0]        va1;
      logic [AW-1:0]        va2;
      logic [31:0]          vp;   // expected complex power (R1, R3)
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{ 12'sd0,     12'sd0,    18'd262143, 18'd262143, 32'd0       },
      '{ 12'sd100,   12'sd0,    18'd262143, 18'd262143, 32'd10000   },
      '{-12'sd100,   12'sd50,   18'd131072, 18'd131072, 32'd12500   },
      '{ 12'sd2047,  12'sd2047, 18'd65536,  18'd200000, 32'd4194303 },
      '{-12'sd2048, -12'sd2048, 18'd262143, 18'd1,      32'd4194303 },
      '{-12'sd2048,  12'sd0,    18'd0,      18'd262143, 32'd4194303 },
      '{ 12'sd1000, -12'sd1000, 18'd100000, 18'd150000, 32'd2000000 },
      '{ 12'sd3,     12'sd4,    18'd262143, 18'd262143, 32'd25      },
      '{-12'sd1,     12'sd0,    18'd262000, 18'd5,      32'd1       },
      '{ 12'sd1448,  12'sd0,    18'd131072, 18'd262143, 32'd2096704 },
      '{ 12'sd0,    -12'sd2048, 18'd262143, 18'd262143, 32'd4194303 },
      '{ 12'sd2047,  12'sd0,    18'd12345,  18'd200000, 32'd4190209 }
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                 init = 1'b1;
   logic                 ena  = 1'b0;
   logic signed [DW-1:0] di = '0, dq = '0;
   logic [AW-1:0]        a1 = '0, a2 = '0;
   logic [OW-1:0]        pw [3];
   logic                 vo [3];

   int     nchk = 0, nfail = 0;
   longint m1 [3], m2 [3];

   pwr_detector #(.DATA_W(DW), .ALPHA_W(AW), .COMPLEX_EN(1'b1), .USE_I(1'b1), .USE_Q(1'b1)) u0 (
      .clk(clk), .init(init), .smp_en(ena), .smp_i(di), .smp_q(dq),
      .alpha1(a1), .alpha2(a2), .pwr_o(pw[0]), .pwr_vld_o(vo[0]));
   pwr_detector #(.DATA_W(DW), .ALPHA_W(AW), .COMPLEX_EN(1'b0), .USE_I(1'b1), .USE_Q(1'b0)) u1 (
      .clk(clk), .init(init), .smp_en(ena), .smp_i(di), .smp_q(dq),
      .alpha1(a1), .alpha2(a2), .pwr_o(pw[1]), .pwr_vld_o(vo[1]));
   pwr_detector #(.DATA_W(DW), .ALPHA_W(AW), .COMPLEX_EN(1'b0), .USE_I(1'b0), .USE_Q(1'b1)) u2 (
      .clk(clk), .init(init), .smp_en(ena), .smp_i(di), .smp_q(dq),
      .alpha1(a1), .alpha2(a2), .pwr_o(pw[2]), .pwr_vld_o(vo[2]));

   function automatic longint sq_pow(int mode, longint i, longint q);
      longint p;
      p = (mode == 0) ? i*i + q*q : (mode == 1) ? i*i : q*q;
      if (p > PMAX) p = PMAX;
      return p;
   endfunction

   function automatic longint ema_step(longint s, longint x, longint a);
      return s + (((x - s) * a) >>> AW);
   endfunction

   function automatic longint model_out(int d);
      return m2[d] >>> AW;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int d = 0; d < 3; d++) begin m1[d] = 0; m2[d] = 0; end
   endtask

   // Drive one enabled sample at a falling edge and advance the model
   task automatic drive(longint i, longint q, longint pc);
      di  = DW'(i);
      dq  = DW'(q);
      ena = 1'b1;
      for (int d = 0; d < 3; d++) begin
         longint p;
         p = (d == 0 && pc >= 0) ? pc : sq_pow(d, i, q);
         m1[d] = ema_step(m1[d], p <<< AW, longint'(a1));
         m2[d] = ema_step(m2[d], m1[d], longint'(a2));
      end
   endtask

   // Isolated sample: result sampled at the fourth falling edge after the driving one
   task automatic send(longint i, longint q, longint pc);
      @(negedge clk);
      drive(i, q, pc);
      @(negedge clk);
      ena = 1'b0;
      repeat (2) @(negedge clk);
      chk(vo[0] == 1'b0, "R5 early strobe", longint'(vo[0]), 0);
      @(negedge clk);
   endtask

   task automatic do_init();
      @(negedge clk);
      init = 1'b1;
      ena  = 1'b0;
      @(negedge clk);
      init = 1'b0;
      model_reset();
   endtask

   longint prev, pexp;
   int     cnt, first;
   bit     ok;
   logic [OW-1:0] held [3];

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      init = 1'b0;
      // R7: state after reset
      for (int d = 0; d < 3; d++)
         chk(pw[d] == '0 && vo[d] == 1'b0, "R7 reset state", longint'(pw[d]), 0);

      // Table walk: R1 (u0), R2 (u1/u2), R3 clamps, R4 exact arithmetic
      for (int v = 0; v < NV; v++) begin
         a1 = VEC[v].va1;
         a2 = VEC[v].va2;
         send(longint'(VEC[v].vi), longint'(VEC[v].vq), longint'(VEC[v].vp));
         chk(vo[0] && longint'(pw[0]) == model_out(0), "R1/R4 complex", longint'(pw[0]), model_out(0));
         chk(vo[1] && longint'(pw[1]) == model_out(1), "R2/R4 I-only", longint'(pw[1]), model_out(1));
         chk(vo[2] && longint'(pw[2]) == model_out(2), "R2/R4 Q-only", longint'(pw[2]), model_out(2));
      end

      // R6: with enable low, inputs wiggle but nothing moves
      for (int d = 0; d < 3; d++) held[d] = pw[d];
      ok = 1'b1;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         di = DW'(c*391 - 2000);
         dq = DW'(1777 - c*333);
         a1 = AW'(c*20011);
         a2 = AW'(AMAX - c*977);
         for (int d = 0; d < 3; d++)
            if (pw[d] != held[d] || vo[d]) ok = 1'b0;
      end
      chk(ok, "R6 disabled inputs ignored", longint'(pw[0]), longint'(held[0]));

      // R3: saturation with max coefficient, complex and real
      do_init();
      a1 = AW'(AMAX); a2 = AW'(AMAX);
      repeat (3) send(-2048, -2048, -1);
      chk(longint'(pw[0]) == model_out(0) && longint'(pw[0]) >= PMAX - 1, "R3 complex clamp", longint'(pw[0]), model_out(0));
      chk(longint'(pw[1]) == model_out(1) && longint'(pw[1]) >= PMAX - 1, "R3 real clamp", longint'(pw[1]), model_out(1));

      // R9: max coefficient tracks a constant within one LSB per stage
      do_init();
      a1 = AW'(AMAX); a2 = AW'(AMAX);
      pexp = 1000000;
      repeat (3) send(1000, 0, -1);
      chk(longint'(pw[1]) <= pexp && longint'(pw[1]) >= pexp - 1, "R9 max alpha tracking", longint'(pw[1]), pexp);
      chk(longint'(pw[0]) == model_out(0), "R9/R4 exact", longint'(pw[0]), model_out(0));

      // R8: monotonic approach to a constant, never past it
      do_init();
      a1 = 18'd16384; a2 = 18'd32768;
      pexp = 250000;
      prev = 0;
      for (int k = 0; k < 8; k++) begin
         send(500, 0, -1);
         chk(longint'(pw[1]) >= prev && longint'(pw[1]) <= pexp && longint'(pw[1]) == model_out(1),
             "R8 monotonic approach", longint'(pw[1]), model_out(1));
         prev = longint'(pw[1]);
      end

      // R10: zero first coefficient freezes the chain at zero
      do_init();
      a1 = '0; a2 = AW'(AMAX);
      repeat (3) send(2047, 2047, -1);
      chk(pw[0] == '0 && pw[1] == '0, "R10 zero alpha freezes", longint'(pw[0]), 0);

      // R5: back-to-back burst, one strobe per sample, first after four edges
      do_init();
      a1 = 18'd100000; a2 = 18'd70000;
      cnt = 0; first = -1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (c < 6) drive(c*300 - 700, 900 - c*250, -1);
         else       ena = 1'b0;
         if (vo[0]) begin cnt++; if (first < 0) first = c; end
      end
      chk(cnt == 6, "R5 strobe count", cnt, 6);
      chk(first == 4, "R5 latency", first, 4);
      chk(longint'(pw[0]) == model_out(0), "R5/R4 burst result", longint'(pw[0]), model_out(0));
      chk(longint'(pw[2]) == model_out(2), "R5/R2 burst Q-only", longint'(pw[2]), model_out(2));

      // R7: init in mid-stream wins over enable and restarts from zero
      do_init();
      a1 = AW'(AMAX); a2 = AW'(AMAX);
      @(negedge clk); drive(1500, -900, -1);
      @(negedge clk); drive(-1200, 300, -1);
      @(negedge clk);
      init = 1'b1;                  // enable stays high during init
      drive(800, 800, -1);
      @(negedge clk);
      init = 1'b0;
      ena  = 1'b0;
      model_reset();
      ok = 1'b1;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         if (vo[0] || pw[0] != '0) ok = 1'b0;
      end
      chk(ok, "R7 mid-stream clear", longint'(pw[0]), 0);
      send(-30, 40, -1);
      chk(vo[0] && longint'(pw[0]) == model_out(0), "R7 restart from zero", longint'(pw[0]), model_out(0));

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule